// File: doc/BRIEF.md
# Two-Beat Burst Split-Port SRAM

This block models a static RAM whose write data and read data travel on separate ports, and where every access moves two words at once. It runs in a single clock domain. The two beats that a double-edge part would move on the rising and falling edges of one cycle both appear side by side in that cycle. A command is taken from an active-low load strobe, a read/write select and a pair address. The pair address names an even/odd word pair.

Writes carry a lane-select mask for each beat. A lane whose select is high is left untouched in storage. Reads come back a fixed number of cycles after the load, with both beats, a valid flag and an output-enable. The output-enable stands in for the three-state driver, and the read port shows zero while it is low.

Writes are staged for one cycle before they reach storage. A read that lands on a pair held in that stage sees the merged result. The lane width and lane count are parameters: nine-bit lanes suit the 18- and 36-bit widths, and four-bit lanes with two selects suit the 8-bit width.

Top module: `burst2_sio_sram`

## Requirements
- R1: A command starts only when `cmd_ld_n` is low at a rising edge. `cmd_rd` high then means read and low means write. While `cmd_ld_n` is high, `cmd_rd`, the address, the data and the selects cause no access and no change to storage.
- R2: A read loaded in cycle c presents both beats in cycle c+RD_LAT, with `rd_valid` and `rd_oe` high for exactly that one cycle. RD_LAT defaults to 2.
- R3: Reads already loaded return on schedule whatever happens on the command inputs afterwards, including idle cycles and further loads.
- R4: Beat 0 (`wr_d0`, `rd_q0`) is the even word of the addressed pair and beat 1 (`wr_d1`, `rd_q1`) is the odd word.
- R5: The pair address is taken only at the loading edge. Changing `cmd_addr` afterwards does not change the data returned.
- R6: Write selects are active low, one per lane and per beat. Lane i covers data bits [i*LANE_W +: LANE_W], so with the defaults lane 0 is bits 8:0, lane 1 is 17:9, lane 2 is 26:18 and lane 3 is 35:27. A lane whose select is 1 keeps its previous contents.
- R7: Whenever `rd_oe` is low, `rd_valid` is low and both read beats are zero.
- R8: A read loaded in the cycle right after a write to the same pair returns the data merged by that write.
- R9: During and just after reset, `rd_valid` and `rd_oe` are low and both read beats are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_ld_n | input | 1 | Load strobe, active low |
| cmd_rd | input | 1 | 1 = read, 0 = write, used only with a load |
| cmd_addr | input | ADDR_W | Pair address |
| wr_d0 | input | LANE_W*LANES | Write data, beat 0 (even word) |
| wr_d1 | input | LANE_W*LANES | Write data, beat 1 (odd word) |
| wr_sel0_n | input | LANES | Active-low lane selects for beat 0 |
| wr_sel1_n | input | LANES | Active-low lane selects for beat 1 |
| rd_q0 | output | LANE_W*LANES | Read data, beat 0 |
| rd_q1 | output | LANE_W*LANES | Read data, beat 1 |
| rd_valid | output | 1 | Read beats are valid this cycle |
| rd_oe | output | 1 | Read port driven; low models a released bus |

## Verification
The hardest case to reach is a read that must take its data from the staged write. This needs a masked write followed at once by a load of the same pair, so that storage still holds the old lanes while the stage holds the new ones. The directed sequence produces exactly this, with partial masks, full masks and back-to-back writes to one pair. A long random phase over a small address space then makes such collisions frequent. Idle cycles are driven with random address, direction, data and all-zero selects, so any command leaking through without a load would corrupt storage. A final read sweep of every pair exposes such corruption.

// File: rtl/b2_pkg.sv
package b2_pkg;
   typedef enum logic [1:0] {
      OP_NONE  = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2
   } op_e;
endpackage

// File: rtl/b2_cmd_decode.sv
module b2_cmd_decode
   import b2_pkg::*;
(
   input  logic ld_n,
   input  logic rd,
   output op_e  op
);
   // R1: the direction bit only matters on a load
   always_comb begin
      if (ld_n)    op = OP_NONE;
      else if (rd) op = OP_READ;
      else         op = OP_WRITE;
   end
endmodule

// File: rtl/b2_lane_merge.sv
module b2_lane_merge #(
   parameter int LANE_W = 9,
   parameter int LANES  = 4,
   localparam int W     = LANE_W * LANES
) (
   input  logic [W-1:0]     base,
   input  logic [W-1:0]     upd,
   input  logic [LANES-1:0] sel_n,
   output logic [W-1:0]     res
);
   // R6: per-lane choice, active-low select
   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign res[i*LANE_W +: LANE_W] = sel_n[i] ? base[i*LANE_W +: LANE_W]
                                                : upd[i*LANE_W +: LANE_W];
   end
endmodule

// File: rtl/b2_read_pipe.sv
module b2_read_pipe #(
   parameter int W     = 36,
   parameter int DEPTH = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_v,
   input  logic [W-1:0] in_q0,
   input  logic [W-1:0] in_q1,
   output logic         out_v,
   output logic [W-1:0] out_q0,
   output logic [W-1:0] out_q1
);
   logic         v_sr  [DEPTH];
   logic [W-1:0] q0_sr [DEPTH];
   logic [W-1:0] q1_sr [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            v_sr[i]  <= 1'b0;
            q0_sr[i] <= '0;
            q1_sr[i] <= '0;
         end
      end else begin
         // R7: data entering without a read is forced to zero
         v_sr[0]  <= in_v;
         q0_sr[0] <= in_v ? in_q0 : '0;
         q1_sr[0] <= in_v ? in_q1 : '0;
         for (int i = 1; i < DEPTH; i++) begin
            v_sr[i]  <= v_sr[i-1];
            q0_sr[i] <= q0_sr[i-1];
            q1_sr[i] <= q1_sr[i-1];
         end
      end
   end

   assign out_v  = v_sr[DEPTH-1];
   assign out_q0 = q0_sr[DEPTH-1];
   assign out_q1 = q1_sr[DEPTH-1];
endmodule

// File: rtl/burst2_sio_sram.sv
module burst2_sio_sram
   import b2_pkg::*;
#(
   parameter int LANE_W   = 9,
   parameter int LANES    = 4,
   parameter int ADDR_W   = 5,
   parameter int RD_LAT   = 2,
   localparam int DATA_W  = LANE_W * LANES,
   localparam int PAIRS   = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_ld_n,
   input  logic              cmd_rd,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [DATA_W-1:0] wr_d0,
   input  logic [DATA_W-1:0] wr_d1,
   input  logic [LANES-1:0]  wr_sel0_n,
   input  logic [LANES-1:0]  wr_sel1_n,
   output logic [DATA_W-1:0] rd_q0,
   output logic [DATA_W-1:0] rd_q1,
   output logic              rd_valid,
   output logic              rd_oe
);
   if (LANE_W < 1 || LANES < 1) begin : g_bad_lanes
      $error("burst2_sio_sram: lane width and count must be positive");
   end
   if (RD_LAT < 1) begin : g_bad_lat
      $error("burst2_sio_sram: RD_LAT must be at least 1");
   end
   if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr
      $error("burst2_sio_sram: ADDR_W out of range");
   end

   op_e op;

   b2_cmd_decode u_dec (
      .ld_n (cmd_ld_n),
      .rd   (cmd_rd),
      .op   (op)
   );

   // storage: index 0 = even word (beat 0), index 1 = odd word (beat 1), R4
   logic [DATA_W-1:0] mem [0:1][0:PAIRS-1];

   // one-cycle write stage
   logic              pend_v;
   logic [ADDR_W-1:0] pend_addr;
   logic [DATA_W-1:0] pend_d   [2];
   logic [LANES-1:0]  pend_sel [2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_v      <= 1'b0;
         pend_addr   <= '0;
         pend_d[0]   <= '0;
         pend_d[1]   <= '0;
         pend_sel[0] <= '1;
         pend_sel[1] <= '1;
      end else begin
         pend_v <= (op == OP_WRITE);
         if (op == OP_WRITE) begin
            // R5: address latched only on the loading edge
            pend_addr   <= cmd_addr;
            pend_d[0]   <= wr_d0;
            pend_d[1]   <= wr_d1;
            pend_sel[0] <= wr_sel0_n;
            pend_sel[1] <= wr_sel1_n;
         end
      end
   end

   // merged image of the staged pair, used to commit and to forward
   logic [DATA_W-1:0] commit_d [2];
   logic [DATA_W-1:0] rd_word  [2];
   logic              fwd_hit;

   assign fwd_hit = pend_v && (pend_addr == cmd_addr);

   for (genvar b = 0; b < 2; b++) begin : g_beat
      b2_lane_merge #(
         .LANE_W (LANE_W),
         .LANES  (LANES)
      ) u_merge (
         .base  (mem[b][pend_addr]),
         .upd   (pend_d[b]),
         .sel_n (pend_sel[b]),
         .res   (commit_d[b])
      );
      // R8: a read behind a staged write sees the merged pair
      assign rd_word[b] = fwd_hit ? commit_d[b] : mem[b][cmd_addr];
   end

   always_ff @(posedge clk) begin
      if (pend_v) begin
         for (int b = 0; b < 2; b++) begin
            mem[b][pend_addr] <= commit_d[b];
         end
      end
   end

   logic pipe_v;

   b2_read_pipe #(
      .W     (DATA_W),
      .DEPTH (RD_LAT)
   ) u_rpipe (
      .clk    (clk),
      .rst_n  (rst_n),
      .in_v   (op == OP_READ),
      .in_q0  (rd_word[0]),
      .in_q1  (rd_word[1]),
      .out_v  (pipe_v),
      .out_q0 (rd_q0),
      .out_q1 (rd_q1)
   );

   // R2, R7: valid and driver enable travel together
   assign rd_valid = pipe_v;
   assign rd_oe    = pipe_v;
endmodule

// File: rtl/burst2_sio_sram_chk.sv
module burst2_sio_sram_chk #(
   parameter int W      = 36,
   parameter int RD_LAT = 2
) (
   input logic         clk,
   input logic         rst_n,
   input logic         ld_n,
   input logic         rd,
   input logic         rd_valid,
   input logic         rd_oe,
   input logic [W-1:0] q0,
   input logic [W-1:0] q1,
   input logic         wr_pend_v
);
   // independent tracker of issued reads, one bit per cycle of latency
   logic [RD_LAT-1:0] rd_track;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_track <= '0;
      else        rd_track <= RD_LAT'((rd_track << 1) | RD_LAT'(!ld_n && rd));
   end

   AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid == rd_track[RD_LAT-1]);                                  // R2

   AST_RELEASE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_oe |-> (!rd_valid && q0 == '0 && q1 == '0));                  // R7

   AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      ld_n |=> !wr_pend_v);                                             // R1

   AST_READ_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_n && rd) |=> !wr_pend_v);                                    // R1

   AST_WRITE_STAGED: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_n && !rd) |=> wr_pend_v);                                    // R1
endmodule

bind burst2_sio_sram burst2_sio_sram_chk #(
   .W      (DATA_W),
   .RD_LAT (RD_LAT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ld_n      (cmd_ld_n),
   .rd        (cmd_rd),
   .rd_valid  (rd_valid),
   .rd_oe     (rd_oe),
   .q0        (rd_q0),
   .q1        (rd_q1),
   .wr_pend_v (pend_v)
);

// File: tb/sim_burst2_sio_sram.sv
module sim_burst2_sio_sram;
   localparam int CLK_P = 10;
   localparam int LW    = 9;
   localparam int NL    = 4;
   localparam int DW    = LW * NL;
   localparam int AW    = 5;
   localparam int NP    = 1 << AW;
   localparam int LAT   = 2;
   localparam int NEXP  = 4096;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ld_n = 1'b1;
   logic          rd = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] d0 = '0, d1 = '0;
   logic [NL-1:0] s0 = '1, s1 = '1;
   logic [DW-1:0] q0, q1;
   logic          qv, qoe;

   always #(CLK_P/2) clk = ~clk;

   burst2_sio_sram #(.LANE_W(LW), .LANES(NL), .ADDR_W(AW), .RD_LAT(LAT)) u0 (
      .clk(clk), .rst_n(rst_n), .cmd_ld_n(ld_n), .cmd_rd(rd), .cmd_addr(addr),
      .wr_d0(d0), .wr_d1(d1), .wr_sel0_n(s0), .wr_sel1_n(s1),
      .rd_q0(q0), .rd_q1(q1), .rd_valid(qv), .rd_oe(qoe)
   );

   int n_run = 0, n_fail = 0, cyc = 0;
   bit            exp_v  [NEXP];
   logic [DW-1:0] exp_q0 [NEXP];
   logic [DW-1:0] exp_q1 [NEXP];
   string         exp_t  [NEXP];
   logic [DW-1:0] ref0 [NP];
   logic [DW-1:0] ref1 [NP];

   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [DW-1:0] rnd_d();
      logic [63:0] t;
      t = {$urandom(), $urandom()};
      return t[DW-1:0];
   endfunction

   // R6: expected effect of a masked beat
   function automatic logic [DW-1:0] merge(logic [DW-1:0] old, logic [DW-1:0] nw,
                                           logic [NL-1:0] sel_n);
      logic [DW-1:0] r;
      r = old;
      for (int i = 0; i < NL; i++)
         if (!sel_n[i]) r[i*LW +: LW] = nw[i*LW +: LW];
      return r;
   endfunction

   task automatic check(bit ok, string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s cycle %0d: actual %h expected %h", req, what, cyc, act, exp);
      end
   endtask

   task automatic check_outputs();
      int c;
      c = cyc;
      check(qv == exp_v[c] && qoe == exp_v[c], "R2", "valid/oe", DW'({qv, qoe}),
            DW'({exp_v[c], exp_v[c]}));
      if (exp_v[c]) begin
         check(q0 == exp_q0[c], exp_t[c], "beat0", q0, exp_q0[c]);
         check(q1 == exp_q1[c], exp_t[c], "beat1", q1, exp_q1[c]);
      end else begin
         check(q0 == '0 && q1 == '0, "R7", "released data", q0 | q1, '0);
      end
   endtask

   // one cycle: check outputs, then present a command
   task automatic step(bit load, bit rd_i, int a, logic [DW-1:0] x0, logic [DW-1:0] x1,
                       logic [NL-1:0] m0, logic [NL-1:0] m1, string t);
      @(negedge clk);
      check_outputs();
      ld_n = !load; rd = rd_i; addr = AW'(a);
      d0 = x0; d1 = x1; s0 = m0; s1 = m1;
      if (load && rd_i) begin
         exp_v[cyc + LAT]  = 1'b1;
         exp_q0[cyc + LAT] = ref0[a];
         exp_q1[cyc + LAT] = ref1[a];
         exp_t[cyc + LAT]  = t;
      end else if (load) begin
         ref0[a] = merge(ref0[a], x0, m0);
         ref1[a] = merge(ref1[a], x1, m1);
      end
   endtask

   // idle with garbage on every other input (R1, R5)
   task automatic idle();
      step(1'b0, 1'($urandom()), int'($urandom() % NP), rnd_d(), rnd_d(), '0, '0, "R1");
   endtask

   task automatic rd_pair(int a, string t);
      step(1'b1, 1'b1, a, rnd_d(), rnd_d(), '0, '0, t);
   endtask

   task automatic wr_pair(int a, logic [DW-1:0] x0, logic [DW-1:0] x1,
                          logic [NL-1:0] m0, logic [NL-1:0] m1);
      step(1'b1, 1'b0, a, x0, x1, m0, m1, "R6");
   endtask

   task automatic finish_up();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   initial begin
      #(CLK_P * 200000);
      n_fail++;
      $display("FAIL watchdog expired: actual hung expected done");
      finish_up();
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < NEXP; i++) begin
         exp_v[i] = 1'b0; exp_q0[i] = '0; exp_q1[i] = '0; exp_t[i] = "R2";
      end
      for (int i = 0; i < NP; i++) begin
         ref0[i] = '0; ref1[i] = '0;
      end
      repeat (3) @(negedge clk);
      // R9: reset state
      check(!qv && !qoe, "R9", "valid/oe in reset", DW'({qv, qoe}), '0);
      check(q0 == '0 && q1 == '0, "R9", "data in reset", q0 | q1, '0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!qv && !qoe && q0 == '0 && q1 == '0, "R9", "after reset", q0 | q1, '0);

      // fill every pair with full writes (R1, R4)
      for (int p = 0; p < NP; p++) wr_pair(p, rnd_d(), rnd_d(), '0, '0);
      idle();
      // R4: even/odd word order
      rd_pair(3, "R4");
      idle(); idle();
      // R6: partial masks per beat
      wr_pair(5, rnd_d(), rnd_d(), 4'b1010, 4'b0111);
      idle();
      rd_pair(5, "R6");
      // R6: fully deselected write changes nothing
      wr_pair(6, rnd_d(), rnd_d(), 4'b1111, 4'b1111);
      idle();
      rd_pair(6, "R6");
      // R8: read right behind a write to the same pair
      wr_pair(9, rnd_d(), rnd_d(), 4'b0101, 4'b1100);
      rd_pair(9, "R8");
      wr_pair(10, rnd_d(), rnd_d(), '0, '0);
      rd_pair(10, "R8");
      wr_pair(11, rnd_d(), rnd_d(), 4'b0011, 4'b1110);
      wr_pair(11, rnd_d(), rnd_d(), 4'b1001, 4'b0110);
      rd_pair(11, "R8");
      // R3: reads in flight finish through idle cycles
      rd_pair(12, "R3");
      rd_pair(13, "R3");
      idle(); idle(); idle();
      // R5: address changes after the load do not matter
      rd_pair(14, "R5");
      step(1'b0, 1'b1, 15, rnd_d(), rnd_d(), '0, '0, "R5");
      step(1'b0, 1'b0, 1, rnd_d(), rnd_d(), '0, '0, "R5");
      // R1: write-looking inputs without a load
      step(1'b0, 1'b0, 16, rnd_d(), rnd_d(), '0, '0, "R1");
      idle();
      rd_pair(16, "R1");
      idle(); idle();

      // random mix over a small address space
      for (int n = 0; n < 2000; n++) begin
         if ($urandom() % 4 == 0) idle();
         else if ($urandom() % 2 == 0) rd_pair(int'($urandom() % NP), "R6");
         else wr_pair(int'($urandom() % NP), rnd_d(), rnd_d(),
                      NL'($urandom()), NL'($urandom()));
      end
      repeat (LAT + 2) idle();

      // final sweep exposes any stray write (R1)
      for (int p = 0; p < NP; p++) rd_pair(p, "R1");
      repeat (LAT + 2) idle();
      finish_up();
   end
endmodule